// File: doc/BRIEF.md
# Frame Start and Line Reference Generator

This block watches the timing of an incoming video stream and marks the start of a frame at a position that software chooses. Position counters clear on the vertical-sync rising edge of the first field (field bit low). From there they count subsamples, samples and lines. A fixed latency that depends on the sync mode is then added. When the counters reach the programmed position, the frame-start output goes high for one divider period.

A second output is the video clock divided by a programmable period. The divider restarts at every frame start, so its rising edge coincides with the frame-start rising edge. Setting the period to the line length in samples turns this output into a once-per-line horizontal reference that an external PLL can lock to. The sync decoding that produces `vsync` and `fieldBit`, and the PLL itself, sit outside the block.

Top module: `frameRefGen`

## Requirements
- R1: During reset, and after reset until a vsync rising edge with `fieldBit` low has been seen, `sofOut` and `refDivOut` stay 0.
- R2: With `sepSyncMode` = 1 and `cfgSample` = `cfgLine` = 0, `sofOut` first reads 1 after the 3rd clock edge that follows the edge at which `vsync` is first sampled high (with `fieldBit` = 0).
- R3: With `sepSyncMode` = 0 and the same zero settings, that delay is 6 clock edges.
- R4: `cfgSample` holds the sample index in bits [SAMPLE_W+1:2] and the subsample index in bits [1:0]. The subsample count steps every clock and wraps after 3. The sample count steps on that wrap and returns to 0 after reaching `cfgDivider`, and each such return advances the line count. With N = `cfgDivider`, the rise delay is LAT + `cfgLine`*4*(N+1) + sample*4 + subsample, where LAT is 3 (separate mode) or 6 (embedded mode).
- R5: A vsync rising edge sampled with `fieldBit` = 1 neither restarts the position counters nor enables the block.
- R6: Once raised, `sofOut` stays 1 for exactly `cfgDivider`+1 clock cycles and then returns to 0.
- R7: `refDivOut` rises on the same edge as `sofOut`. It then repeats with period P = `cfgDivider`+1 cycles, high for floor(P/2) cycles and low for the rest of each period.
- R8: A new vsync rising edge with `fieldBit` = 0 in the middle of a frame restarts counting, so the next `sofOut` rise is measured from the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rstN | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync, active high |
| fieldBit | input | 1 | Field indicator; 0 marks the field that starts counting |
| sepSyncMode | input | 1 | 1 = separate sync timing (latency 3), 0 = embedded (latency 6) |
| cfgSample | input | SAMPLE_W+2 | Target sample index in the upper bits, subsample in bits [1:0] |
| cfgLine | input | LINE_W | Target line index |
| cfgDivider | input | SAMPLE_W | Divider value N; period N+1, also the last sample index of a line |
| sofOut | output | 1 | Frame-start output; a rising edge marks the frame start |
| refDivOut | output | 1 | Divided clock, re-phased to every frame start |

## Verification
The bench sweeps both sync modes and positions that use the subsample, sample and line fields, and checks each measured rise delay against the formula. A wrong pipeline tap or a counter that wraps in the wrong place shows up as an off-by-some delay. Mid-frame vsync edges in either field test the restart rule. A design that clears on field 1 would fire early, and one that ignores a new field-0 edge would fire at the stale position. After each rise, the bench follows the frame-start width and the divider waveform for two periods, which catches a divider that is not re-phased and any duty or width error of one cycle.

// File: rtl/frameRefPkg.sv
package frameRefPkg;

  // Strobes from position control to the output datapath
  typedef struct packed {
    logic fire;   // frame-start position reached, latency already applied
    logic armed;  // a first-field vsync has been seen since reset
  } ctlStrobe_t;

endpackage

// File: rtl/frameCtl.sv
module frameCtl
  import frameRefPkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LINE_W   = 11,
  parameter int SEP_LAT  = 3,
  parameter int EMB_LAT  = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  vsync,
  input  logic                  fieldBit,
  input  logic                  sepSyncMode,
  input  logic [SAMPLE_W+1:0]   cfgSample,
  input  logic [LINE_W-1:0]     cfgLine,
  input  logic [SAMPLE_W-1:0]   cfgDivider,
  output ctlStrobe_t            strobe
);

  // match is formed one cycle after the clearing edge and sofOut is one
  // register after the tap, so a latency of LAT uses pipe stage LAT-2
  localparam int PIPE_D  = EMB_LAT - 1;
  localparam int SEP_TAP = SEP_LAT - 2;
  localparam int EMB_TAP = EMB_LAT - 2;

  logic                vsyncQ;
  logic                vsRise;
  logic                f0Start;
  logic [1:0]          subCnt;
  logic [SAMPLE_W-1:0] sampCnt;
  logic [LINE_W-1:0]   lineCnt;
  logic                armed;
  logic                sampWrap;
  logic                matchHit;
  logic [PIPE_D-1:0]   matchPipe;

  assign vsRise   = vsync & ~vsyncQ;
  assign f0Start  = vsRise & ~fieldBit;
  assign sampWrap = (subCnt == 2'd3) && (sampCnt >= cfgDivider);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsyncQ <= 1'b0;
    end else begin
      vsyncQ <= vsync;
    end
  end

  // Position counters: subsample every clock, sample on subsample wrap,
  // line on sample wrap at the divider value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt  <= '0;
      sampCnt <= '0;
      lineCnt <= '0;
      armed   <= 1'b0;
    end else if (f0Start) begin
      subCnt  <= '0;
      sampCnt <= '0;
      lineCnt <= '0;
      armed   <= 1'b1;
    end else begin
      subCnt <= subCnt + 2'd1;
      if (subCnt == 2'd3) begin
        sampCnt <= sampWrap ? '0 : sampCnt + 1'b1;
      end
      if (sampWrap) begin
        lineCnt <= lineCnt + 1'b1;
      end
    end
  end

  assign matchHit = armed && !f0Start
                 && (subCnt  == cfgSample[1:0])
                 && (sampCnt == cfgSample[SAMPLE_W+1:2])
                 && (lineCnt == cfgLine);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPipe <= '0;
    end else begin
      matchPipe <= {matchPipe[PIPE_D-2:0], matchHit};
    end
  end

  // Mode picks the tap; when both latencies coincide there is one tap only
  generate
    if (SEP_TAP == EMB_TAP) begin : gOneTap
      assign strobe.fire = matchPipe[EMB_TAP];
    end else begin : gTwoTap
      assign strobe.fire = sepSyncMode ? matchPipe[SEP_TAP] : matchPipe[EMB_TAP];
    end
  endgenerate

  assign strobe.armed = armed;

  AST_NO_EARLY_SOF: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !strobe.fire);  // R1

  AST_F1_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (vsRise && fieldBit) |=> (subCnt == $past(subCnt) + 2'd1));  // R5

  AST_LINE_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!f0Start && !(subCnt == 2'd3)) |=> $stable(lineCnt));  // R4

endmodule

// File: rtl/frameDp.sv
module frameDp
  import frameRefPkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] cfgDivider,
  output logic                sofOut,
  output logic                refDivOut
);

  localparam int PER_W = SAMPLE_W + 1;

  logic [PER_W-1:0]    period;
  logic [PER_W-1:0]    halfPer;
  logic [SAMPLE_W-1:0] divCnt;
  logic [SAMPLE_W-1:0] divNext;
  logic [SAMPLE_W-1:0] sofCnt;

  assign period  = {1'b0, cfgDivider} + 1'b1;
  assign halfPer = period >> 1;

  // Divider restarts on every frame start so its edge lands on sofOut's
  always_comb begin
    if (strobe.fire) begin
      divNext = '0;
    end else if (divCnt >= cfgDivider) begin
      divNext = '0;
    end else begin
      divNext = divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      refDivOut <= 1'b0;
    end else if (!strobe.armed) begin
      divCnt    <= '0;
      refDivOut <= 1'b0;
    end else begin
      divCnt    <= divNext;
      refDivOut <= ({1'b0, divNext} < halfPer);
    end
  end

  // Frame-start pulse: high for one divider period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sofOut <= 1'b0;
      sofCnt <= '0;
    end else if (strobe.fire) begin
      sofOut <= 1'b1;
      sofCnt <= cfgDivider;
    end else if (sofCnt != '0) begin
      sofCnt <= sofCnt - 1'b1;
    end else begin
      sofOut <= 1'b0;
    end
  end

  AST_SOF_FROM_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sofOut) |-> $past(strobe.fire));  // R6

  AST_SOF_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sofOut) && cfgDivider != '0) |-> refDivOut);  // R7

  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.armed |=> !refDivOut);  // R1

endmodule

// File: rtl/frameRefGen.sv
module frameRefGen
  import frameRefPkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LINE_W   = 11,
  parameter int SEP_LAT  = 3,
  parameter int EMB_LAT  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                vsync,
  input  logic                fieldBit,
  input  logic                sepSyncMode,
  input  logic [SAMPLE_W+1:0] cfgSample,
  input  logic [LINE_W-1:0]   cfgLine,
  input  logic [SAMPLE_W-1:0] cfgDivider,
  output logic                sofOut,
  output logic                refDivOut
);

  ctlStrobe_t strobe;

  frameCtl #(
    .SAMPLE_W (SAMPLE_W),
    .LINE_W   (LINE_W),
    .SEP_LAT  (SEP_LAT),
    .EMB_LAT  (EMB_LAT)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .vsync       (vsync),
    .fieldBit    (fieldBit),
    .sepSyncMode (sepSyncMode),
    .cfgSample   (cfgSample),
    .cfgLine     (cfgLine),
    .cfgDivider  (cfgDivider),
    .strobe      (strobe)
  );

  frameDp #(
    .SAMPLE_W (SAMPLE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgDivider (cfgDivider),
    .sofOut     (sofOut),
    .refDivOut  (refDivOut)
  );

endmodule

// File: tb/frameRefGen_tb.sv
`timescale 1ns/1ps
module frameRefGen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vsync = 1'b0;
  logic        fieldBit = 1'b0;
  logic        sepSyncMode = 1'b0;
  logic [13:0] cfgSample = '0;
  logic [10:0] cfgLine = '0;
  logic [11:0] cfgDivider = '0;
  logic        sofOut;
  logic        refDivOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  frameRefGen u_dut (
    .clk(clk), .rstN(rstN), .vsync(vsync), .fieldBit(fieldBit),
    .sepSyncMode(sepSyncMode), .cfgSample(cfgSample), .cfgLine(cfgLine),
    .cfgDivider(cfgDivider), .sofOut(sofOut), .refDivOut(refDivOut)
  );

  // Columns: sepMode, sampleField, line, divider, expected rise delay
  localparam int NVEC = 6;
  localparam int VEC [NVEC][5] = '{
    '{1,  0, 0, 5,  3},   // R2
    '{0,  0, 0, 5,  6},   // R3
    '{1,  9, 0, 5, 12},   // R4 sample 2 sub 1
    '{0,  7, 1, 3, 29},   // R4 sample 1 sub 3 line 1
    '{1, 12, 2, 3, 47},   // R4 sample 3 line 2
    '{0, 22, 1, 7, 60}    // R4 sample 5 sub 2 line 1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int sep, input int samp, input int line, input int div);
    @(negedge clk);
    rstN = 1'b0; vsync = 1'b0; fieldBit = 1'b0;
    sepSyncMode = sep[0]; cfgSample = samp[13:0];
    cfgLine = line[10:0]; cfgDivider = div[11:0];
    repeat (3) @(negedge clk);
    check(sofOut == 1'b0 && refDivOut == 1'b0, "R1 reset outputs", {sofOut, refDivOut}, 0);
    rstN = 1'b1;
  endtask

  // F0 vsync, optional extra vsync at loop index extraAt; returns rise index
  task automatic runFrame(input int extraAt, input bit extraField, output int riseAt);
    riseAt = -1;
    @(posedge clk); #1; vsync = 1'b1; fieldBit = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 200; k++) begin
      if (k > 0) @(posedge clk);
      #1;
      if (k == 2) vsync = 1'b0;
      if (extraAt > 0 && k == extraAt) begin vsync = 1'b1; fieldBit = extraField; end
      if (extraAt > 0 && k == extraAt + 2) begin vsync = 1'b0; fieldBit = 1'b0; end
      @(negedge clk);
      if (sofOut) begin
        riseAt = k;
        break;
      end
    end
  endtask

  // Called at the negedge where sofOut is first seen high
  task automatic checkWave(input int div);
    int per;
    per = div + 1;
    check(refDivOut == 1'b1, "R7 refDivOut high at frame start", refDivOut, 1);
    for (int j = 1; j < 2 * per; j++) begin
      @(negedge clk);
      check(sofOut == (j < per), "R6 sofOut width", sofOut, (j < per));
      check(refDivOut == ((j % per) < (per / 2)), "R7 refDivOut waveform", refDivOut,
            ((j % per) < (per / 2)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    int rise;
    bit quiet;

    // Table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      doReset(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      repeat (5) @(negedge clk);
      runFrame(0, 1'b0, rise);
      check(rise == VEC[v][4], "R4 rise delay (R2/R3 at zero position)", rise, VEC[v][4]);
      if (rise >= 0) checkWave(VEC[v][3]);
    end

    // R1: no output after reset without any vsync
    doReset(1, 0, 0, 5);
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sofOut || refDivOut) quiet = 1'b0;
    end
    check(quiet, "R1 idle until first-field vsync", !quiet, 0);

    // R5: vsync in field 1 alone does not enable the block
    @(negedge clk); vsync = 1'b1; fieldBit = 1'b1;
    repeat (2) @(negedge clk);
    vsync = 1'b0; fieldBit = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sofOut || refDivOut) quiet = 1'b0;
    end
    check(quiet, "R5 field-1 vsync does not arm", !quiet, 0);

    // R5: field-1 vsync mid-frame does not restart counting
    doReset(1, 12, 2, 3);
    repeat (5) @(negedge clk);
    runFrame(10, 1'b1, rise);
    check(rise == 47, "R5 field-1 vsync keeps position", rise, 47);

    // R8: field-0 vsync mid-frame restarts counting (edge at index 21)
    doReset(1, 12, 2, 3);
    repeat (5) @(negedge clk);
    runFrame(20, 1'b0, rise);
    check(rise == 68, "R8 restart on new field-0 vsync", rise, 68);
    if (rise >= 0) checkWave(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule